// File: doc/BRIEF.md
# PHY Calibration and DLL Power Sequencer

This block brings a high-speed storage-interface PHY out of power-down in a fixed order. On a power-on request it first holds both analog controls low so the pad-calibration logic resets. It then raises the power-up control and waits for the calibration window. It samples the calibration-done flag once. If calibration succeeded, it raises the DLL enable, waits out the lock window and samples the DLL-ready flag once. The analog calibration engine and the DLL sit outside the block, and their status arrives on two inputs.

A power-off request drops both controls at once. It aborts any bring-up in progress and wins over a power-on request in the same cycle. While a bring-up runs, `busy_o` is high and further power-on requests are ignored. When the sequence ends, `done_o` rises and `result_o` reports success, a calibration timeout or a DLL timeout. Both hold until the next accepted request. Every window length is set in microseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset, `pwr_up_o`, `dll_en_o`, `busy_o`, `done_o` are 0 and `result_o` is 0.
- R2: A power-on request accepted while idle makes, at the next edge, `pwr_up_o`=0, `dll_en_o`=0, `busy_o`=1, `done_o`=0 and `result_o`=0, even if the controls were high before.
- R3: After acceptance both controls stay low for exactly QUIET cycles (CLK_MHZ*QUIET_US), and then `pwr_up_o` rises.
- R4: `cal_done_i` is sampled only once, on the edge CAL cycles after `pwr_up_o` rose. If it is 1, `dll_en_o` rises on that edge. Its value at any other time has no effect.
- R5: If `cal_done_i` is 0 at its sample, both controls go low, `busy_o`=0, `done_o`=1 and `result_o`=1 (calibration timeout).
- R6: `dll_ready_i` is sampled only once, on the edge LOCK cycles after `dll_en_o` rose. If it is 1, `busy_o`=0, `done_o`=1 and `result_o`=0, and both controls stay high.
- R7: If `dll_ready_i` is 0 at its sample, both controls go low, `done_o`=1 and `result_o`=2 (DLL timeout). Code 3 never appears.
- R8: A power-off request makes, at the next edge, both controls 0, `busy_o`=0, `done_o`=1 and `result_o`=0. It aborts any bring-up in progress, and no calibration step follows it.
- R9: When power-on and power-off requests arrive in the same cycle, the power-off request wins.
- R10: A power-on request while `busy_o`=1 is ignored, and the running sequence keeps its timing.
- R11: `done_o` and `result_o` hold their values while idle until the next accepted request. `busy_o` and `done_o` are never both 1.
- R12: `dll_en_o` is never 1 while `pwr_up_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_on_req_i | input | 1 | Request a full bring-up (one-cycle pulse) |
| pwr_off_req_i | input | 1 | Request power-down (one-cycle pulse), has priority |
| cal_done_i | input | 1 | Pad calibration finished flag from the PHY |
| dll_ready_i | input | 1 | DLL locked flag from the PHY |
| pwr_up_o | output | 1 | PHY power-up control (low = powered down) |
| dll_en_o | output | 1 | PHY DLL enable |
| busy_o | output | 1 | Bring-up in progress |
| done_o | output | 1 | Last request has completed |
| result_o | output | 2 | 0 success, 1 calibration timeout, 2 DLL timeout |

## Verification
The bench drives each status flag to the opposite of its sampled value for the whole window and sets the right value only in the cycle before the sample edge. A design that sampled early, polled continuously or latched the first high value would then report the wrong outcome. It counts the quiet, calibration and lock windows edge by edge, so an off-by-one counter load shows up as a control that changes one cycle early or late. It also sends a power-on pulse in the middle of the lock window and a simultaneous on/off pair, which would expose a sequencer that restarts when busy or that lets power-on win. A power-off request during calibration must leave the controls low for longer than the calibration window. This catches a design that keeps running its timers after the abort.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_QUIET = 2'd1,
    ST_CAL   = 2'd2,
    ST_LOCK  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RES_OK      = 2'd0,
    RES_CAL_TMO = 2'd1,
    RES_DLL_TMO = 2'd2
  } seq_result_e;

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import phy_seq_pkg::*;
#(
  parameter int W         = 12,
  parameter int QUIET_CYC = 300,
  parameter int CAL_CYC   = 600,
  parameter int LOCK_CYC  = 3000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         on_req_i,
  input  logic         off_req_i,
  input  logic         cal_done_i,
  input  logic         dll_ready_i,
  input  logic         expired_i,
  output logic         load_o,
  output logic [W-1:0] load_val_o,
  output logic         pwr_up_o,
  output logic         dll_en_o,
  output logic         busy_o,
  output logic         done_o,
  output logic [1:0]   result_o
);

  localparam logic [W-1:0] QUIET_LD = W'(QUIET_CYC - 1);
  localparam logic [W-1:0] CAL_LD   = W'(CAL_CYC - 1);
  localparam logic [W-1:0] LOCK_LD  = W'(LOCK_CYC - 1);

  seq_state_e  st_q, st_d;
  logic        pwr_d, dll_d, busy_d, done_d;
  seq_result_e res_q, res_d;

  always_comb begin
    st_d       = st_q;
    pwr_d      = pwr_up_o;
    dll_d      = dll_en_o;
    busy_d     = busy_o;
    done_d     = done_o;
    res_d      = res_q;
    load_o     = 1'b0;
    load_val_o = '0;
    if (off_req_i) begin
      st_d   = ST_IDLE;
      pwr_d  = 1'b0;
      dll_d  = 1'b0;
      busy_d = 1'b0;
      done_d = 1'b1;
      res_d  = RES_OK;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (on_req_i) begin
            st_d       = ST_QUIET;
            pwr_d      = 1'b0;
            dll_d      = 1'b0;
            busy_d     = 1'b1;
            done_d     = 1'b0;
            res_d      = RES_OK;
            load_o     = 1'b1;
            load_val_o = QUIET_LD;
          end
        end
        ST_QUIET: begin
          if (expired_i) begin
            st_d       = ST_CAL;
            pwr_d      = 1'b1;
            load_o     = 1'b1;
            load_val_o = CAL_LD;
          end
        end
        ST_CAL: begin
          if (expired_i) begin
            if (cal_done_i) begin
              st_d       = ST_LOCK;
              dll_d      = 1'b1;
              load_o     = 1'b1;
              load_val_o = LOCK_LD;
            end else begin
              st_d   = ST_IDLE;
              pwr_d  = 1'b0;
              dll_d  = 1'b0;
              busy_d = 1'b0;
              done_d = 1'b1;
              res_d  = RES_CAL_TMO;
            end
          end
        end
        ST_LOCK: begin
          if (expired_i) begin
            st_d   = ST_IDLE;
            busy_d = 1'b0;
            done_d = 1'b1;
            if (dll_ready_i) begin
              res_d = RES_OK;
            end else begin
              pwr_d = 1'b0;
              dll_d = 1'b0;
              res_d = RES_DLL_TMO;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pwr_up_o <= 1'b0;
      dll_en_o <= 1'b0;
      busy_o   <= 1'b0;
      done_o   <= 1'b0;
      res_q    <= RES_OK;
    end else begin
      st_q     <= st_d;
      pwr_up_o <= pwr_d;
      dll_en_o <= dll_d;
      busy_o   <= busy_d;
      done_o   <= done_d;
      res_q    <= res_d;
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/phy_bringup_seq.sv
module phy_bringup_seq #(
  parameter int CLK_MHZ  = 100,
  parameter int QUIET_US = 3,
  parameter int CAL_US   = 6,
  parameter int LOCK_US  = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_on_req_i,
  input  logic       pwr_off_req_i,
  input  logic       cal_done_i,
  input  logic       dll_ready_i,
  output logic       pwr_up_o,
  output logic       dll_en_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] result_o
);

  localparam int QUIET_CYC = CLK_MHZ * QUIET_US;
  localparam int CAL_CYC   = CLK_MHZ * CAL_US;
  localparam int LOCK_CYC  = CLK_MHZ * LOCK_US;
  localparam int MAX_A     = (QUIET_CYC > CAL_CYC) ? QUIET_CYC : CAL_CYC;
  localparam int MAX_CYC   = (MAX_A > LOCK_CYC) ? MAX_A : LOCK_CYC;
  localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  seq_timer #(.W(CNT_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  seq_ctrl #(
    .W         (CNT_W),
    .QUIET_CYC (QUIET_CYC),
    .CAL_CYC   (CAL_CYC),
    .LOCK_CYC  (LOCK_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .on_req_i    (pwr_on_req_i),
    .off_req_i   (pwr_off_req_i),
    .cal_done_i  (cal_done_i),
    .dll_ready_i (dll_ready_i),
    .expired_i   (tmr_expired),
    .load_o      (tmr_load),
    .load_val_o  (tmr_val),
    .pwr_up_o    (pwr_up_o),
    .dll_en_o    (dll_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .result_o    (result_o)
  );

endmodule

// File: rtl/phy_bringup_seq_checker.sv
module phy_bringup_seq_checker #(
  parameter int QUIET_CYC = 300,
  parameter int CAL_CYC   = 600
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_on_req_i,
  input logic       pwr_off_req_i,
  input logic       cal_done_i,
  input logic       pwr_up_o,
  input logic       dll_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic [1:0] result_o
);

  int low_cnt;
  int cal_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) begin
      low_cnt <= 0;
      cal_cnt <= 0;
    end else begin
      if (!pwr_up_o) low_cnt <= low_cnt + 1;
      if (pwr_up_o && !dll_en_o) cal_cnt <= cal_cnt + 1;
    end
  end

  AST_ON_START: assert property (@(posedge clk) disable iff (rst)
    (pwr_on_req_i && !pwr_off_req_i && !busy_o) |=>
      (busy_o && !pwr_up_o && !dll_en_o && !done_o && result_o == 2'd0)); // R2

  AST_QUIET_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_up_o) |-> (low_cnt == QUIET_CYC)); // R3

  AST_CAL_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(dll_en_o) |-> (cal_cnt == CAL_CYC && $past(cal_done_i))); // R4

  AST_OFF_WINS: assert property (@(posedge clk) disable iff (rst)
    pwr_off_req_i |=>
      (!pwr_up_o && !dll_en_o && !busy_o && done_o && result_o == 2'd0)); // R8

  AST_RESULT_LEGAL: assert property (@(posedge clk) disable iff (rst)
    result_o != 2'd3); // R7

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !pwr_on_req_i && !pwr_off_req_i) |=>
      ($stable(result_o) && $stable(done_o))); // R11

  AST_DLL_UNDER_PWR: assert property (@(posedge clk) disable iff (rst)
    dll_en_o |-> pwr_up_o); // R12

endmodule

bind phy_bringup_seq phy_bringup_seq_checker #(
  .QUIET_CYC (QUIET_CYC),
  .CAL_CYC   (CAL_CYC)
) u_checker (
  .clk           (clk),
  .rst           (rst),
  .pwr_on_req_i  (pwr_on_req_i),
  .pwr_off_req_i (pwr_off_req_i),
  .cal_done_i    (cal_done_i),
  .pwr_up_o      (pwr_up_o),
  .dll_en_o      (dll_en_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .result_o      (result_o)
);

// File: tb/phy_bringup_seq_test.sv
module phy_bringup_seq_test;

  localparam int MHZ = 2;
  localparam int Q   = MHZ * 3;
  localparam int C   = MHZ * 6;
  localparam int L   = MHZ * 30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       on_req = 1'b0;
  logic       off_req = 1'b0;
  logic       cal_done = 1'b0;
  logic       dll_ready = 1'b0;
  logic       pwr_up, dll_en, busy, done;
  logic [1:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  phy_bringup_seq #(
    .CLK_MHZ (MHZ), .QUIET_US (3), .CAL_US (6), .LOCK_US (30)
  ) uut (
    .clk           (clk),
    .rst           (rst),
    .pwr_on_req_i  (on_req),
    .pwr_off_req_i (off_req),
    .cal_done_i    (cal_done),
    .dll_ready_i   (dll_ready),
    .pwr_up_o      (pwr_up),
    .dll_en_o      (dll_en),
    .busy_o        (busy),
    .done_o        (done),
    .result_o      (result)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_all(input string tag, input int p, input int d,
                            input int b, input int dn, input int r);
    chk({tag, " pwr_up"}, int'(pwr_up), p);
    chk({tag, " dll_en"}, int'(dll_en), d);
    chk({tag, " busy"}, int'(busy), b);
    chk({tag, " done"}, int'(done), dn);
    chk({tag, " result"}, int'(result), r);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(3);
    expect_all("R1 reset", 0, 0, 0, 0, 0);
    rst = 1'b0;
    step(1);
    expect_all("R1 after release", 0, 0, 0, 0, 0);
  endtask

  // Flags are held at the opposite of the sampled value except in the sample cycle.
  task automatic t_bringup(input bit cal_smp, input bit dll_smp, input bit poke_busy);
    cal_done  = !cal_smp;
    dll_ready = !dll_smp;
    on_req = 1'b1;
    step(1);
    on_req = 1'b0;
    expect_all("R2 start", 0, 0, 1, 0, 0);
    step(Q - 1);
    chk("R3 still quiet", int'(pwr_up), 0);
    step(1);
    chk("R3 pwr_up rise", int'(pwr_up), 1);
    chk("R12 dll low in cal", int'(dll_en), 0);
    step(C - 1);
    chk("R4 no early dll", int'(dll_en), 0);
    cal_done = cal_smp;
    step(1);
    cal_done = !cal_smp;
    if (!cal_smp) begin
      expect_all("R5 cal timeout", 0, 0, 0, 1, 1);
      return;
    end
    chk("R4 dll_en rise", int'(dll_en), 1);
    chk("R4 busy", int'(busy), 1);
    if (poke_busy) begin
      on_req = 1'b1;
      step(1);
      on_req = 1'b0;
      chk("R10 on ignored busy", int'(busy), 1);
      chk("R10 on ignored pwr", int'(pwr_up), 1);
      step(L - 2);
    end else begin
      step(L - 1);
    end
    chk("R6 still locking", int'(busy), 1);
    chk("R6 dll held", int'(dll_en), 1);
    dll_ready = dll_smp;
    step(1);
    dll_ready = !dll_smp;
    if (dll_smp) expect_all("R6 success", 1, 1, 0, 1, 0);
    else         expect_all("R7 dll timeout", 0, 0, 0, 1, 2);
  endtask

  task automatic t_hold(input int exp_res);
    step(25);
    chk("R11 result held", int'(result), exp_res);
    chk("R11 done held", int'(done), 1);
  endtask

  task automatic t_off_idle();
    off_req = 1'b1;
    step(1);
    off_req = 1'b0;
    expect_all("R8 off", 0, 0, 0, 1, 0);
    step(Q + C + 5);
    chk("R8 no cal after off", int'(pwr_up), 0);
  endtask

  task automatic t_abort();
    cal_done = 1'b1;
    dll_ready = 1'b1;
    on_req = 1'b1;
    step(1);
    on_req = 1'b0;
    step(Q + 3);
    chk("R8 abort mid cal pwr", int'(pwr_up), 1);
    off_req = 1'b1;
    step(1);
    off_req = 1'b0;
    expect_all("R8 abort", 0, 0, 0, 1, 0);
    step(C + L);
    chk("R8 abort stays low pwr", int'(pwr_up), 0);
    chk("R8 abort stays low dll", int'(dll_en), 0);
  endtask

  task automatic t_both();
    on_req = 1'b1;
    off_req = 1'b1;
    step(1);
    on_req = 1'b0;
    off_req = 1'b0;
    expect_all("R9 off wins", 0, 0, 0, 1, 0);
    step(Q + 2);
    chk("R9 no bringup", int'(pwr_up), 0);
    chk("R9 not busy", int'(busy), 0);
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_bringup(1'b1, 1'b1, 1'b0);
    t_bringup(1'b1, 1'b1, 1'b1);
    t_off_idle();
    t_bringup(1'b0, 1'b1, 1'b0);
    t_hold(1);
    t_bringup(1'b1, 1'b0, 1'b0);
    t_hold(2);
    t_abort();
    t_both();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      report();
      $finish;
    end
  end

endmodule